// File: doc/BRIEF.md
# Switch Ingress Forward-State Filter

This block sits between the address lookup stage and the transmit queues of a multi-port Ethernet switch. For each received frame it receives the candidate transmit-port mask from the lookup. It then narrows that mask using a forwarding state held for every port. Each port's state is one of Disabled, Blocked, Learning or Forwarding, and the host programs it through a simple write port.

The test applied to the receive port depends on the destination type. A unicast frame relies on the BLOCK and SECURE bits of its table entry. A multicast frame relies on a two-bit required-state field from its entry. Every transmit port, whatever the frame type, must itself be Forwarding to stay in the mask.

Frames the MAC marks as errored never enable learning. When the receive port's pass-errors enable is set and the frame was not aborted, the frame goes to the host port alone as a bypass frame. Otherwise it is dropped. The verdict (mask, learn enable, drop, bypass) is registered and appears one clock after the input strobe.

Top module: `fwd_state_filter`

## Requirements
- R1: After reset every port state reads Disabled. The state bus `port_states` carries port p in bits [2p+1:2p] with the encoding 00 Disabled, 01 Blocked, 10 Learning, 11 Forwarding.
- R2: A host write (`cfg_we` high) loads `cfg_state` into the port selected by `cfg_port`, visible on `port_states` one clock later. Other ports are unchanged.
- R3: `out_valid` rises exactly one clock after `in_valid`. Outputs are all zero in any cycle that follows a cycle without `in_valid`.
- R4: When the receive port is Disabled, the verdict is an empty mask with drop set and learn and bypass clear, for every frame type and error flag.
- R5: For a good (non-bypass) frame, an output mask bit is set only if the candidate bit is set and that transmit port is Forwarding.
- R6: For a unicast destination with both BLOCK and SECURE set, any receive state other than Disabled passes the frame.
- R7: For a unicast destination without both BLOCK and SECURE set, the frame passes only when the receive port is Forwarding.
- R8: The multicast bit is `dst_mac[40]`, the least significant bit of the first octet `dst_mac[47:40]`. When it is set, the required-state field selects which receive states pass: 00 any non-disabled state, 01 Blocked or above, 10 Learning or Forwarding, 11 Forwarding only.
- R9: A frame with `in_err` or `in_abort` set never asserts `out_learn`.
- R10: An errored frame that is not aborted, on a port whose `pass_err_en` bit is set, yields a mask holding only the host port bit, with bypass set and drop clear. Any other errored frame yields an empty mask with drop set.
- R11: For an error-free frame, `out_learn` is set exactly when the receive port is Learning or Forwarding, whether or not the frame passes.
- R12: `out_drop` is set for a valid frame exactly when its output mask is empty.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Host write strobe for a port state |
| cfg_port | input | PORT_W | Port addressed by the write |
| cfg_state | input | 2 | State value to write |
| port_states | output | 2*NUM_PORTS | Current state of every port |
| pass_err_en | input | NUM_PORTS | Per-port pass-errors enable |
| in_valid | input | 1 | Frame descriptor strobe |
| in_rx_port | input | PORT_W | Receive port of the frame |
| in_dst_mac | input | 48 | Destination MAC address |
| in_cand_mask | input | NUM_PORTS | Candidate transmit ports from lookup |
| in_block | input | 1 | Entry BLOCK bit (unicast) |
| in_secure | input | 1 | Entry SECURE bit (unicast) |
| in_mc_req | input | 2 | Entry multicast required-state field |
| in_err | input | 1 | MAC error flag |
| in_abort | input | 1 | MAC abort flag |
| out_valid | output | 1 | Verdict valid |
| out_mask | output | NUM_PORTS | Filtered transmit-port mask |
| out_learn | output | 1 | Learning permitted for this frame |
| out_drop | output | 1 | Frame dropped (empty mask) |
| out_bypass | output | 1 | Errored frame sent to host only |

## Verification
A corrupted state bank shows directly on `port_states` on the clock after the write. It also shows one clock later in the mask of the next frame, as a transmit bit that appears or vanishes, or as a learn enable that disagrees with the receive state. A wrong receive-port test shows on the very next verdict, as a pass that should have been a drop or the reverse. The random mix of states, entry bits and error flags reaches each of the four receive states under both frame types within a few hundred frames. A wrong error path shows as a stray learn or a mask other than the lone host bit.

// File: rtl/fwd_filter_pkg.sv
package fwd_filter_pkg;

   typedef enum logic [1:0] {
      PS_DISABLED   = 2'b00,
      PS_BLOCKED    = 2'b01,
      PS_LEARNING   = 2'b10,
      PS_FORWARDING = 2'b11
   } port_state_e;

   typedef enum logic [1:0] {
      MR_ANY     = 2'b00,
      MR_BLK_UP  = 2'b01,
      MR_LRN_UP  = 2'b10,
      MR_FWD     = 2'b11
   } mc_req_e;

   // Multicast receive-port check: the required level is a minimum state.
   function automatic logic mc_allows(port_state_e st, mc_req_e rq);
      if (st == PS_DISABLED) return 1'b0;
      if (rq == MR_ANY)      return 1'b1;
      return (logic'(st >= port_state_e'(rq)));
   endfunction

endpackage

// File: rtl/fwd_state_bank.sv
module fwd_state_bank
   import fwd_filter_pkg::*;
#(
   parameter int NUM_PORTS = 8,
   parameter int PORT_W    = 3
) (
   input  logic                   clk,
   input  logic                   rst,
   input  logic                   wr_en,
   input  logic [PORT_W-1:0]      wr_port,
   input  logic [1:0]             wr_state,
   output logic [2*NUM_PORTS-1:0] states_flat,
   output logic [NUM_PORTS-1:0]   fwd_vec
);

   for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port
      port_state_e st_q;

      always_ff @(posedge clk) begin
         if (rst)
            st_q <= PS_DISABLED;
         else if (wr_en && (wr_port == PORT_W'(p)))
            st_q <= port_state_e'(wr_state);
      end

      assign states_flat[2*p +: 2] = st_q;
      assign fwd_vec[p]            = (st_q == PS_FORWARDING);
   end

endmodule

// File: rtl/fwd_rx_judge.sv
module fwd_rx_judge
   import fwd_filter_pkg::*;
#(
   parameter int NUM_PORTS = 8,
   parameter int PORT_W    = 3
) (
   input  logic [2*NUM_PORTS-1:0] states_flat,
   input  logic [NUM_PORTS-1:0]   pass_err_en,
   input  logic [PORT_W-1:0]      rx_port,
   input  logic                   is_mc,
   input  logic                   blk,
   input  logic                   sec,
   input  logic [1:0]             mc_req,
   input  logic                   err,
   input  logic                   abort,
   output logic                   rx_off,
   output logic                   rx_pass,
   output logic                   learn_ok,
   output logic                   err_bypass
);

   logic        in_range;
   port_state_e rx_st;
   logic        rx_pe;
   logic        errored;
   logic        uc_ok;
   logic        mc_ok;

   // Range guard only needed when the port count leaves unused encodings.
   if ((1 << PORT_W) == NUM_PORTS) begin : g_full
      assign in_range = 1'b1;
   end else begin : g_sparse
      assign in_range = (rx_port < PORT_W'(NUM_PORTS));
   end

   always_comb begin
      rx_st = PS_DISABLED;
      rx_pe = 1'b0;
      for (int p = 0; p < NUM_PORTS; p++) begin
         if (in_range && (rx_port == PORT_W'(p))) begin
            rx_st = port_state_e'(states_flat[2*p +: 2]);
            rx_pe = pass_err_en[p];
         end
      end
   end

   assign errored    = err | abort;
   assign rx_off     = (rx_st == PS_DISABLED);
   assign uc_ok      = (blk & sec) | (rx_st == PS_FORWARDING);
   assign mc_ok      = mc_allows(rx_st, mc_req_e'(mc_req));
   assign rx_pass    = !rx_off && !errored && (is_mc ? mc_ok : uc_ok);
   assign learn_ok   = !rx_off && !errored &&
                       ((rx_st == PS_LEARNING) || (rx_st == PS_FORWARDING));
   assign err_bypass = !rx_off && err && !abort && rx_pe;

endmodule

// File: rtl/fwd_tx_gate.sv
module fwd_tx_gate #(
   parameter int NUM_PORTS = 8,
   parameter int HOST_PORT = 0
) (
   input  logic [NUM_PORTS-1:0] cand,
   input  logic [NUM_PORTS-1:0] fwd_vec,
   input  logic                 rx_pass,
   input  logic                 err_bypass,
   output logic [NUM_PORTS-1:0] mask,
   output logic                 empty
);

   for (genvar p = 0; p < NUM_PORTS; p++) begin : g_tx
      if (p == HOST_PORT) begin : g_host
         assign mask[p] = err_bypass | (rx_pass & cand[p] & fwd_vec[p]);
      end else begin : g_net
         assign mask[p] = !err_bypass & rx_pass & cand[p] & fwd_vec[p];
      end
   end

   assign empty = ~|mask;

endmodule

// File: rtl/fwd_state_filter.sv
module fwd_state_filter #(
   parameter int NUM_PORTS = 8,
   parameter int HOST_PORT = 0,
   parameter int DA_W      = 48,
   localparam int PORT_W   = (NUM_PORTS > 1) ? $clog2(NUM_PORTS) : 1,
   localparam int MC_BIT   = DA_W - 8
) (
   input  logic                   clk,
   input  logic                   rst,
   input  logic                   cfg_we,
   input  logic [PORT_W-1:0]      cfg_port,
   input  logic [1:0]             cfg_state,
   output logic [2*NUM_PORTS-1:0] port_states,
   input  logic [NUM_PORTS-1:0]   pass_err_en,
   input  logic                   in_valid,
   input  logic [PORT_W-1:0]      in_rx_port,
   input  logic [DA_W-1:0]        in_dst_mac,
   input  logic [NUM_PORTS-1:0]   in_cand_mask,
   input  logic                   in_block,
   input  logic                   in_secure,
   input  logic [1:0]             in_mc_req,
   input  logic                   in_err,
   input  logic                   in_abort,
   output logic                   out_valid,
   output logic [NUM_PORTS-1:0]   out_mask,
   output logic                   out_learn,
   output logic                   out_drop,
   output logic                   out_bypass
);

   if (NUM_PORTS < 2) begin : g_bad_ports
      $error("NUM_PORTS must be at least 2");
   end
   if (HOST_PORT < 0 || HOST_PORT >= NUM_PORTS) begin : g_bad_host
      $error("HOST_PORT must name an existing port");
   end
   if (DA_W < 8 || (DA_W % 8) != 0) begin : g_bad_da
      $error("DA_W must be a whole number of octets");
   end

   logic [NUM_PORTS-1:0] fwd_vec;
   logic                 rx_off;
   logic                 rx_pass;
   logic                 learn_ok;
   logic                 err_bypass;
   logic [NUM_PORTS-1:0] mask_c;
   logic                 empty_c;

   fwd_state_bank #(.NUM_PORTS(NUM_PORTS), .PORT_W(PORT_W)) u_bank (
      .clk        (clk),
      .rst        (rst),
      .wr_en      (cfg_we),
      .wr_port    (cfg_port),
      .wr_state   (cfg_state),
      .states_flat(port_states),
      .fwd_vec    (fwd_vec)
   );

   fwd_rx_judge #(.NUM_PORTS(NUM_PORTS), .PORT_W(PORT_W)) u_judge (
      .states_flat(port_states),
      .pass_err_en(pass_err_en),
      .rx_port    (in_rx_port),
      .is_mc      (in_dst_mac[MC_BIT]),
      .blk        (in_block),
      .sec        (in_secure),
      .mc_req     (in_mc_req),
      .err        (in_err),
      .abort      (in_abort),
      .rx_off     (rx_off),
      .rx_pass    (rx_pass),
      .learn_ok   (learn_ok),
      .err_bypass (err_bypass)
   );

   fwd_tx_gate #(.NUM_PORTS(NUM_PORTS), .HOST_PORT(HOST_PORT)) u_gate (
      .cand      (in_cand_mask),
      .fwd_vec   (fwd_vec),
      .rx_pass   (rx_pass),
      .err_bypass(err_bypass),
      .mask      (mask_c),
      .empty     (empty_c)
   );

   always_ff @(posedge clk) begin
      if (rst) begin
         out_valid  <= 1'b0;
         out_mask   <= '0;
         out_learn  <= 1'b0;
         out_drop   <= 1'b0;
         out_bypass <= 1'b0;
      end else begin
         out_valid  <= in_valid;
         out_mask   <= in_valid ? mask_c : '0;
         out_learn  <= in_valid & learn_ok;
         out_drop   <= in_valid & (empty_c | rx_off);
         out_bypass <= in_valid & err_bypass;
      end
   end

endmodule

// File: rtl/fwd_filter_chk.sv
module fwd_filter_chk #(
   parameter int NUM_PORTS = 8,
   parameter int HOST_PORT = 0,
   parameter int DA_W      = 48,
   parameter int PORT_W    = 3
) (
   input logic                   clk,
   input logic                   rst,
   input logic [2*NUM_PORTS-1:0] port_states,
   input logic                   in_valid,
   input logic [PORT_W-1:0]      in_rx_port,
   input logic [NUM_PORTS-1:0]   in_cand_mask,
   input logic                   in_err,
   input logic                   in_abort,
   input logic                   out_valid,
   input logic [NUM_PORTS-1:0]   out_mask,
   input logic                   out_learn,
   input logic                   out_drop,
   input logic                   out_bypass
);

   logic [NUM_PORTS-1:0] fwd_now;
   logic                 rx_dis_now;

   always_comb begin
      rx_dis_now = 1'b1;
      for (int p = 0; p < NUM_PORTS; p++) begin
         fwd_now[p] = (port_states[2*p +: 2] == 2'b11);
         if (in_rx_port == PORT_W'(p)) rx_dis_now = (port_states[2*p +: 2] == 2'b00);
      end
   end

   p_reset_disabled_r1: assert property (@(posedge clk)
      $past(rst) |-> (port_states == '0));

   p_latency_r3: assert property (@(posedge clk) disable iff (rst)
      in_valid |=> out_valid);

   p_idle_quiet_r3: assert property (@(posedge clk) disable iff (rst)
      !in_valid |=> (!out_valid && out_mask == '0 && !out_learn && !out_drop));

   p_rx_disabled_r4: assert property (@(posedge clk) disable iff (rst)
      (in_valid && rx_dis_now) |=> (out_drop && out_mask == '0 && !out_learn));

   p_tx_forwarding_r5: assert property (@(posedge clk) disable iff (rst)
      in_valid |=> (out_bypass || ((out_mask & ~($past(fwd_now) & $past(in_cand_mask))) == '0)));

   p_err_no_learn_r9: assert property (@(posedge clk) disable iff (rst)
      (in_valid && (in_err || in_abort)) |=> !out_learn);

   p_bypass_host_r10: assert property (@(posedge clk) disable iff (rst)
      out_bypass |-> (out_mask == NUM_PORTS'(1) << HOST_PORT) && !out_drop && !out_learn);

   p_drop_empty_r12: assert property (@(posedge clk) disable iff (rst)
      out_valid |-> (out_drop == (out_mask == '0)));

endmodule

bind fwd_state_filter fwd_filter_chk #(
   .NUM_PORTS(NUM_PORTS), .HOST_PORT(HOST_PORT), .DA_W(DA_W), .PORT_W(PORT_W)
) u_chk (
   .clk         (clk),
   .rst         (rst),
   .port_states (port_states),
   .in_valid    (in_valid),
   .in_rx_port  (in_rx_port),
   .in_cand_mask(in_cand_mask),
   .in_err      (in_err),
   .in_abort    (in_abort),
   .out_valid   (out_valid),
   .out_mask    (out_mask),
   .out_learn   (out_learn),
   .out_drop    (out_drop),
   .out_bypass  (out_bypass)
);

// File: tb/fwd_state_filter_test.sv
`timescale 1ns/1ps
module fwd_state_filter_test;
   localparam int NP   = 8;
   localparam int HOST = 0;
   localparam int PW   = 3;

   logic          clk = 1'b0;
   logic          rst = 1'b1;
   logic          cfg_we = 1'b0;
   logic [PW-1:0] cfg_port = '0;
   logic [1:0]    cfg_state = '0;
   logic [2*NP-1:0] port_states;
   logic [NP-1:0] pass_err_en = '0;
   logic          in_valid = 1'b0;
   logic [PW-1:0] in_rx_port = '0;
   logic [47:0]   in_dst_mac = '0;
   logic [NP-1:0] in_cand_mask = '0;
   logic          in_block = 1'b0, in_secure = 1'b0;
   logic [1:0]    in_mc_req = '0;
   logic          in_err = 1'b0, in_abort = 1'b0;
   logic          out_valid;
   logic [NP-1:0] out_mask;
   logic          out_learn, out_drop, out_bypass;

   int n_tests = 0;
   int n_fail  = 0;
   logic [1:0] shadow [NP];

   always #2.5 clk = ~clk;

   fwd_state_filter #(.NUM_PORTS(NP), .HOST_PORT(HOST)) uut (
      .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_port(cfg_port), .cfg_state(cfg_state),
      .port_states(port_states), .pass_err_en(pass_err_en), .in_valid(in_valid),
      .in_rx_port(in_rx_port), .in_dst_mac(in_dst_mac), .in_cand_mask(in_cand_mask),
      .in_block(in_block), .in_secure(in_secure), .in_mc_req(in_mc_req),
      .in_err(in_err), .in_abort(in_abort), .out_valid(out_valid), .out_mask(out_mask),
      .out_learn(out_learn), .out_drop(out_drop), .out_bypass(out_bypass));

   task automatic chk(string tag, logic [63:0] act, logic [63:0] exp);
      n_tests++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   // Expected verdict packed as {bypass, drop, learn, mask}.
   function automatic logic [NP+2:0] model(int rx, logic [47:0] da, logic [NP-1:0] cand,
                                           logic b, logic s, logic [1:0] rq, logic e, logic a);
      logic [1:0]    st = shadow[rx];
      logic [NP-1:0] fw = '0;
      logic          ok;
      logic [NP-1:0] m;
      for (int p = 0; p < NP; p++) fw[p] = (shadow[p] == 2'b11);
      if (st == 2'b00) return {1'b0, 1'b1, 1'b0, {NP{1'b0}}};
      if (e || a) begin
         if (e && !a && pass_err_en[rx])
            return {1'b1, 1'b0, 1'b0, NP'(1) << HOST};
         return {1'b0, 1'b1, 1'b0, {NP{1'b0}}};
      end
      if (da[40]) ok = (rq == 2'b00) ? 1'b1 : (st >= rq);
      else        ok = (b && s) || (st == 2'b11);
      m = ok ? (cand & fw) : '0;
      return {1'b0, (m == '0), (st[1] == 1'b1), m};
   endfunction

   task automatic write_state(int port, logic [1:0] v);
      @(negedge clk);
      cfg_we = 1'b1; cfg_port = PW'(port); cfg_state = v;
      @(posedge clk); #1;
      cfg_we = 1'b0;
      shadow[port] = v;
      chk("R2 state bus after write", 64'(port_states[2*port +: 2]), 64'(v));
   endtask

   task automatic frame(string tag, int rx, logic [47:0] da, logic [NP-1:0] cand,
                        logic b, logic s, logic [1:0] rq, logic e, logic a);
      logic [NP+2:0] exp;
      @(negedge clk);
      in_valid = 1'b1; in_rx_port = PW'(rx); in_dst_mac = da; in_cand_mask = cand;
      in_block = b; in_secure = s; in_mc_req = rq; in_err = e; in_abort = a;
      exp = model(rx, da, cand, b, s, rq, e, a);
      @(posedge clk); #1;
      chk("R3 out_valid", 64'(out_valid), 64'd1);
      chk(tag, 64'({out_bypass, out_drop, out_learn, out_mask}), 64'(exp));
      @(negedge clk);
      in_valid = 1'b0;
   endtask

   localparam logic [47:0] UC = 48'h02_11_22_33_44_55;
   localparam logic [47:0] MC = 48'h01_00_5e_00_00_01;

   initial begin
      #(5.0 * 150000);
      n_fail++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

   initial begin
      void'($urandom(32'h5eed_1234));
      for (int p = 0; p < NP; p++) shadow[p] = 2'b00;
      repeat (3) @(posedge clk);
      #1;
      chk("R1 all ports disabled after reset", 64'(port_states), 64'd0);
      chk("R3 out_valid low in reset", 64'(out_valid), 64'd0);
      @(negedge clk); rst = 1'b0;

      frame("R4 disabled rx unicast", 2, UC, 8'hff, 1, 1, 0, 0, 0);
      frame("R4 disabled rx errored", 2, UC, 8'hff, 0, 0, 0, 1, 0);
      @(posedge clk); #1;
      chk("R3 quiet after idle cycle", 64'({out_valid, out_mask, out_drop}), 64'd0);

      for (int p = 0; p < NP; p++) write_state(p, 2'b11);
      write_state(3, 2'b00);
      frame("R5 tx mask drops disabled port", 1, UC, 8'b0000_1110, 0, 0, 0, 0, 0);
      write_state(1, 2'b01);
      frame("R6 unicast block+secure from blocked", 1, UC, 8'b0011_0000, 1, 1, 0, 0, 0);
      frame("R7 unicast block only from blocked", 1, UC, 8'b0011_0000, 1, 0, 0, 0, 0);
      write_state(1, 2'b10);
      frame("R7 unicast from learning", 1, UC, 8'b0011_0000, 0, 1, 0, 0, 0);
      frame("R11 learn from learning port", 1, UC, 8'h00, 0, 0, 0, 0, 0);
      for (int q = 0; q < 4; q++) begin
         frame("R8 multicast learning rx vs required level", 1, MC, 8'hf0, 0, 0, 2'(q), 0, 0);
      end
      write_state(1, 2'b01);
      frame("R8 multicast blocked rx, req any", 1, MC, 8'hf0, 0, 0, 2'b00, 0, 0);
      frame("R8 multicast blocked rx, req learning", 1, MC, 8'hf0, 0, 0, 2'b10, 0, 0);
      pass_err_en = 8'b0000_0100;
      frame("R10 errored, pass enabled -> host only", 2, UC, 8'hfe, 1, 1, 0, 1, 0);
      frame("R10 aborted -> drop", 2, UC, 8'hfe, 1, 1, 0, 1, 1);
      frame("R9 errored, pass disabled, no learn", 4, MC, 8'hfe, 0, 0, 0, 1, 0);
      frame("R12 empty candidate -> drop", 4, UC, 8'h00, 0, 0, 0, 0, 0);

      for (int i = 0; i < 600; i++) begin
         logic [47:0] da;
         if ($urandom_range(3) == 0)
            write_state(int'($urandom_range(NP-1)), 2'($urandom_range(3)));
         if ($urandom_range(7) == 0) pass_err_en = NP'($urandom);
         da = {$urandom, 16'($urandom)};
         frame("R4-R12 random frame verdict", int'($urandom_range(NP-1)), da, NP'($urandom),
               1'($urandom), 1'($urandom), 2'($urandom),
               ($urandom_range(5) == 0), ($urandom_range(9) == 0));
      end

      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end
endmodule